// File: doc/BRIEF.md
# Controller-Mode Audio Clock Generator

This block produces the bit clock and frame sync of a serial audio port when the port acts as clock controller. It runs entirely on the system clock (CCLK). Two mode pins choose how the frame rate is obtained. The frame rate is either a fixed fraction of CCLK (1/256 or 1/128), or a fixed 96 kHz or 48 kHz family rate. A format input selects two-channel I2S framing or TDM framing. A ratio input tells the block how fast CCLK is relative to the 48 kHz or 44.1 kHz family base rate. The word length is fixed at 32 bits.

All configuration inputs are captured only while reset is held. From the captured values the block derives two counts: CCLK cycles per frame and bit clocks per frame. It checks that they divide into a whole number of CCLK cycles per bit. When they do, it starts a clean frame on the first cycle after reset is released. When they do not, it raises a configuration error and keeps its clock outputs quiet.

Top module: `ctl_clkgen`

## Requirements
- R1: `mode_pins`, `fmt_tdm` and `cclk_ratio` are captured on every clock edge during which `rst_n` is low. Changes to them while `rst_n` is high have no effect on `bclk`, `fsync`, `locked` or `cfg_err`.
- R2: The number of CCLK cycles per frame (F) is selected by `mode_pins`:
  - 2'b00 gives 256.
  - 2'b01 gives 128.
  - 2'b10 (fixed 96 kHz family) gives `cclk_ratio`/2.
  - 2'b11 (fixed 48 kHz family) gives `cclk_ratio`.
  Here `cclk_ratio` is CCLK divided by the family base rate.
- R3: The number of bit clocks per frame (P) is set as follows:
  - Modes 2'b00 and 2'b01 with I2S (`fmt_tdm`=0): 64.
  - Modes 2'b00 and 2'b01 with TDM: 256 when `cclk_ratio` <= F, 128 when F < `cclk_ratio` <= 2F, and 64 above that.
  - Mode 2'b10: 128.
  - Mode 2'b11: 256.
- R4: Each bit lasts D = F/P CCLK cycles and begins with a falling edge of `bclk`. When D >= 2, `bclk` is low for the first ceil(D/2) cycles of the bit and high for the rest. When D = 1, `bclk` equals the inverted CCLK, low in the first half of each CCLK period.
- R5: In I2S framing, `fsync` is low for bits 0 to P/2-1 of a frame and high for bits P/2 to P-1. It changes only together with a falling edge of `bclk`.
- R6: In TDM framing, `fsync` is high exactly during bit 0 of each frame and low during all other bits.
- R7: `cfg_err` is 1 when any of the following holds: F is 0, mode 2'b10 has an odd `cclk_ratio`, F is not a multiple of P, or F < P. While `cfg_err` is 1, `bclk`, `fsync` and `locked` stay 0.
- R8: While `rst_n` is low, `bclk`, `fsync` and `locked` are 0. On the first cycle after the first rising clock edge with `rst_n` high, a valid configuration has `locked` = 1 and is at CCLK cycle 0 of bit 0 of frame 0. `locked` then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock CCLK |
| rst_n | input | 1 | Synchronous active-low reset; configuration capture window |
| mode_pins | input | 2 | Frame-rate mode select |
| fmt_tdm | input | 1 | 0 = I2S framing, 1 = TDM framing |
| cclk_ratio | input | RATIO_W | CCLK divided by the 48/44.1 kHz base rate |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync (I2S level or TDM pulse) |
| locked | output | 1 | Clocks are running |
| cfg_err | output | 1 | Captured configuration cannot be generated |

## Verification
The last CCLK cycle of a frame is also the last cycle of a bit. The following edge therefore wraps the cycle counter and the bit counter together, and `fsync` must change in the same cycle as the `bclk` falling edge. This happens twice per frame in I2S and once per frame in TDM. The coincidence is provoked with D = 1, 2, 3 and 4, including the odd divide and the pass-through case. Every CCLK cycle over two frames is compared with counts derived from the requirements. Reset release also coincides with the start of frame 0, so the first sampled cycle must already show bit 0 framing.

// File: rtl/ctl_clkgen.sv
module ctl_clkgen #(
  parameter int RATIO_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_pins,
  input  logic               fmt_tdm,
  input  logic [RATIO_W-1:0] cclk_ratio,
  output logic               bclk,
  output logic               fsync,
  output logic               locked,
  output logic               cfg_err
);

  localparam int CW = RATIO_W + 1;

  logic [1:0]         mode_q;
  logic               tdm_q;
  logic [RATIO_W-1:0] ratio_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= mode_pins;
      tdm_q   <= fmt_tdm;
      ratio_q <= cclk_ratio;
    end
  end

  logic [CW-1:0] per_frame, per_bit, bits, low_len, ratio_x;
  logic [3:0]    bits_log;
  logic          err, div1;

  assign ratio_x = CW'(ratio_q);

  always_comb begin
    case (mode_q)
      2'b00:   per_frame = CW'(256);
      2'b01:   per_frame = CW'(128);
      2'b10:   per_frame = ratio_x >> 1;
      default: per_frame = ratio_x;
    endcase
    case (mode_q)
      2'b10:   bits_log = 4'd7;
      2'b11:   bits_log = 4'd8;
      default:
        if (!tdm_q)                        bits_log = 4'd6;
        else if (ratio_x <= per_frame)     bits_log = 4'd8;
        else if (ratio_x <= (per_frame << 1)) bits_log = 4'd7;
        else                               bits_log = 4'd6;
    endcase
    bits    = CW'(1) << bits_log;
    per_bit = per_frame >> bits_log;
    low_len = per_bit - (per_bit >> 1);
    err     = (per_frame == '0) || (mode_q == 2'b10 && ratio_q[0]) ||
              ((per_frame & (bits - CW'(1))) != '0) || (per_bit == '0);
    div1    = (per_bit == CW'(1));
  end

  logic          active;
  logic [CW-1:0] cyc, bit_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cyc    <= '0;
      bit_n  <= '0;
    end else if (!err) begin
      active <= 1'b1;
      if (active) begin
        if (cyc == per_bit - CW'(1)) begin
          cyc   <= '0;
          bit_n <= (bit_n == bits - CW'(1)) ? '0 : bit_n + CW'(1);
        end else begin
          cyc <= cyc + CW'(1);
        end
      end
    end
  end

  assign bclk    = active & (div1 ? ~clk : (cyc >= low_len));
  assign fsync   = active & (tdm_q ? (bit_n == '0) : (bit_n >= (bits >> 1)));
  assign locked  = active;
  assign cfg_err = err;

endmodule

// File: rtl/ctl_clkgen_chk.sv
module ctl_clkgen_chk (
  input logic clk,
  input logic rst_n,
  input logic bclk,
  input logic fsync,
  input logic locked,
  input logic cfg_err,
  input logic div_one
);

  logic was_rst;
  always_ff @(posedge clk) was_rst <= !rst_n;

  always @(posedge clk) begin
    if (was_rst == 1'b1) begin
      assert_quiet_in_reset_R8: assert (!locked && !bclk && !fsync);
    end
  end

  assert_fsync_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked) && !div_one && (fsync != $past(fsync)))
      |-> (!bclk && $past(bclk)));

  assert_err_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!bclk && !fsync && !locked));

  assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> locked);

  assert_lock_excl_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(locked && cfg_err));

endmodule

bind ctl_clkgen ctl_clkgen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
  .locked(locked), .cfg_err(cfg_err), .div_one(div1)
);

// File: tb/ctl_clkgen_tb.sv
`timescale 1ns/1ps
module ctl_clkgen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_pins = 2'b00;
  logic        fmt_tdm = 1'b0;
  logic [11:0] cclk_ratio = 12'd256;
  logic        bclk, fsync, locked, cfg_err;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  ctl_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins), .fmt_tdm(fmt_tdm),
    .cclk_ratio(cclk_ratio), .bclk(bclk), .fsync(fsync),
    .locked(locked), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_reset(input logic [1:0] m, input logic t, input int r);
    rst_n = 1'b0; mode_pins = m; fmt_tdm = t; cclk_ratio = 12'(r);
    repeat (3) @(posedge clk);
    #1;
    chk(!locked && !bclk && !fsync, "R8 reset outputs", {locked, bclk, fsync}, 0);
    rst_n = 1'b1;
  endtask

  task automatic run_cfg(input logic [1:0] m, input logic t, input int r,
                         input int frame, input int bits, input bit swap);
    int per;
    per = frame / bits;
    apply_reset(m, t, r);
    for (int n = 0; n < 2 * frame; n++) begin
      int c, b, eb, ef;
      @(posedge clk); #1;
      c  = n % per;
      b  = (n / per) % bits;
      eb = (per == 1) ? 0 : (c >= per - per / 2);
      ef = t ? (b == 0) : (b >= bits / 2);
      chk(locked == 1'b1 && cfg_err == 1'b0, "R8 lock", locked, 1);
      chk(bclk == eb, swap ? "R1 bclk after input change" : "R4 bclk", bclk, eb);
      chk(fsync == ef, t ? "R6 tdm fsync" : "R5 i2s fsync", fsync, ef);
      if (per == 1) begin
        #2.5;
        chk(bclk == 1'b1, "R4 pass-through high half", bclk, 1);
      end
      if (swap && n == 10) begin
        mode_pins = 2'b11; fmt_tdm = ~t; cclk_ratio = 12'd768;
      end
    end
  endtask

  task automatic run_err(input logic [1:0] m, input logic t, input int r);
    apply_reset(m, t, r);
    for (int n = 0; n < 40; n++) begin
      @(posedge clk); #1;
      chk(cfg_err == 1'b1, "R7 error flag", cfg_err, 1);
      chk(!locked && !bclk && !fsync, "R7 outputs quiet", {locked, bclk, fsync}, 0);
    end
  endtask

  initial begin
    run_cfg(2'b00, 1'b0, 256, 256, 64, 1'b0);   // R2 R3 R5
    run_cfg(2'b00, 1'b1, 256, 256, 256, 1'b0);  // R3 R4 D=1
    run_cfg(2'b00, 1'b1, 512, 256, 128, 1'b0);  // R3 mid rate
    run_cfg(2'b00, 1'b1, 1024, 256, 64, 1'b0);  // R3 high rate
    run_cfg(2'b01, 1'b0, 128, 128, 64, 1'b0);   // R2
    run_cfg(2'b01, 1'b1, 256, 128, 128, 1'b0);  // R3 D=1
    run_cfg(2'b10, 1'b0, 512, 256, 128, 1'b0);  // R2 fixed 96k
    run_cfg(2'b11, 1'b1, 768, 768, 256, 1'b0);  // R4 odd D=3
    run_err(2'b10, 1'b0, 511);                  // R7 odd ratio
    run_err(2'b01, 1'b1, 128);                  // R7 F < P
    run_err(2'b11, 1'b0, 0);                    // R7 zero frame
    run_cfg(2'b00, 1'b0, 256, 256, 64, 1'b1);   // R1
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule